// File: doc/BRIEF.md
# Multi-Mode Interval Counter Channel

This block is a single 16-bit down-counting channel of a programmable interval timer. It advances on a count-enable tick, watches a gate input, and drives one output pin whose waveform depends on one of six counting modes: terminal-count flag, retriggerable one-shot, rate pulse, square wave, software strobe and gate-started strobe. Counting can run in plain binary or in four-digit BCD.

A host-side wrapper supplies a mode code, a BCD flag and a 16-bit count together on a single-cycle load strobe. The channel exposes its live count and its output level. Register decoding, count latching and interrupt delivery stay outside the block.

Within one clock cycle a load takes precedence over a gate rising edge, and a gate rising edge takes precedence over a tick. All outputs are registered and change on the clock edge that samples the event.

Top module: `tmr_channel`

## Requirements
- R1: After reset the output is low and the count reads 0. Ticks and gate activity have no effect until the first load.
- R2: A load captures the mode code, the BCD flag and the count. Mode codes 6 and 7 act as modes 2 and 3. A loaded count of 0 acts as 65536 ticks in binary and 10000 ticks in BCD.
- R3: In modes 0, 1, 4 and 5 the count keeps decrementing past zero, wrapping to FFFF in binary or to 9999 in BCD.
- R4: Mode 0 drives the output low at load. The output goes high on the tick that brings the count to zero and stays high until the next load.
- R5: Mode 1 drives the output high at load or at restart. It goes low on the tick that brings the count to zero.
- R6: Mode 2 reloads the initial count on the tick where the count would reach zero. The output is high for exactly the one clock after that tick. The load itself produces no pulse.
- R7: Mode 3 subtracts two per tick. For an initial count N, the output is high for (N+1)/2 ticks and low for N/2 ticks (integer division), and this repeats. With N=1 the output stays high.
- R8: Mode 4 pulses the output high for one clock after the tick that brings the count to zero, and does so only once per load.
- R9: Mode 5 behaves like mode 4. It counts regardless of gate level, and a gate rising edge rearms the single pulse.
- R10: In modes 0 and 4 a low gate suspends counting and a gate rising edge has no effect. In modes 1, 2, 3 and 5 the gate level is ignored and a rising edge restarts from the initial count.
- R11: A load with a mode and BCD flag different from the current ones restarts at once. A load in modes 0, 1, 4 and 5 always restarts at once. A load that repeats the current mode 2 or 3 and BCD flag changes only the value used at the next reload.
- R12: In one cycle, load beats gate rising edge, and gate rising edge beats tick. With no tick, load or restart, the count holds.
- R13: In BCD mode each 4-bit digit of the count (bits 3:0 lowest) stays in 0..9, provided loaded values are valid BCD.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Mode code, sampled on load (6 and 7 alias 2 and 3) |
| bcd_i | input | 1 | 1 selects BCD counting, sampled on load |
| load_i | input | 1 | Single-cycle load strobe |
| load_val_i | input | 16 | Initial count, sampled on load (0 means maximum) |
| gate_i | input | 1 | Gate level |
| tick_i | input | 1 | Count-enable tick |
| count_o | output | 16 | Live count value |
| out_o | output | 1 | Output pin level |

## Verification
The gate rising-edge restart and the counting tick can land in the same cycle, and so can a load and a gate edge. The bench drives each of these pairs deliberately, including a tick that would otherwise have been terminal. An untimed reference model resolves every cycle by the stated priority: load, then restart, then tick. Its count and pin are compared with the design on every clock, so a wrong winner shows up as a count that is off by one step or as a stray or missing pulse.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W = 16;
  localparam int DIG_N = CNT_W / 4;

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [2:0]       mode_t;

  // Fold aliased codes 6/7 onto 2/3
  function automatic mode_t f_norm_mode(mode_t m);
    return (m[2:1] == 2'b11) ? {1'b0, m[1:0]} : m;
  endfunction

  function automatic logic f_retrig(mode_t m);
    return (m == 3'd1) || (m == 3'd2) || (m == 3'd3) || (m == 3'd5);
  endfunction

  function automatic logic f_level_gated(mode_t m);
    return (m == 3'd0) || (m == 3'd4);
  endfunction

  function automatic logic f_pulse_mode(mode_t m);
    return (m == 3'd2) || (m == 3'd4) || (m == 3'd5);
  endfunction

  function automatic logic f_periodic(mode_t m);
    return (m == 3'd2) || (m == 3'd3);
  endfunction

  // Subtract one or two, in binary or per-digit BCD
  function automatic cnt_t f_dec(cnt_t v, logic bcd, logic two);
    cnt_t r;
    logic [4:0] t;
    logic b;
    logic [4:0] sub;
    if (!bcd) begin
      r = v - (two ? cnt_t'(2) : cnt_t'(1));
    end else begin
      r = '0;
      b = 1'b0;
      for (int i = 0; i < DIG_N; i++) begin
        sub = (i == 0) ? (two ? 5'd2 : 5'd1) : 5'd0;
        t = {1'b0, v[i*4 +: 4]} - sub - {4'd0, b};
        if (t[4]) begin
          t = t + 5'd10;
          r[i*4 +: 4] = t[3:0];
          b = 1'b1;
        end else begin
          r[i*4 +: 4] = t[3:0];
          b = 1'b0;
        end
      end
    end
    return r;
  endfunction

  // Round an odd count up to even (wraps at the modulus)
  function automatic cnt_t f_even_up(cnt_t v, logic bcd);
    cnt_t r;
    logic c;
    if (!v[0]) return v;
    if (!bcd) return v + cnt_t'(1);
    r = v;
    c = 1'b1;
    for (int i = 0; i < DIG_N; i++) begin
      if (c) begin
        if (v[i*4 +: 4] == 4'd9) begin
          r[i*4 +: 4] = 4'd0;
        end else begin
          r[i*4 +: 4] = v[i*4 +: 4] + 4'd1;
          c = 1'b0;
        end
      end
    end
    return r;
  endfunction

  // Round down to even: clearing bit 0 is valid for both codings
  function automatic cnt_t f_even_down(cnt_t v);
    return {v[CNT_W-1:1], 1'b0};
  endfunction
endpackage

// File: rtl/tmr_edge.sv
module tmr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic rise_o
);
  logic d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) d_q <= 1'b0;
    else        d_q <= d_i;
  end

  assign rise_o = d_i & ~d_q;
endmodule

// File: rtl/tmr_cfg.sv
module tmr_cfg
  import tmr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_i,
  input  mode_t mode_i,
  input  logic  bcd_i,
  input  cnt_t  val_i,
  output logic  armed_o,
  output logic  start_o,
  output mode_t mode_o,
  output logic  bcd_o,
  output cnt_t  init_o
);
  mode_t mode_q;
  logic  bcd_q;
  cnt_t  init_q;
  logic  armed_q;
  mode_t mode_n;
  logic  defer;

  assign mode_n = f_norm_mode(mode_i);
  // Same periodic mode and coding: new value waits for the next reload
  assign defer  = armed_q && (mode_n == mode_q) && f_periodic(mode_n) && (bcd_i == bcd_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      bcd_q   <= 1'b0;
      init_q  <= '0;
      armed_q <= 1'b0;
    end else if (load_i) begin
      mode_q  <= mode_n;
      bcd_q   <= bcd_i;
      init_q  <= val_i;
      armed_q <= 1'b1;
    end
  end

  assign armed_o = armed_q;
  assign start_o = load_i && !defer;
  assign mode_o  = load_i ? mode_n : mode_q;
  assign bcd_o   = load_i ? bcd_i  : bcd_q;
  assign init_o  = load_i ? val_i  : init_q;
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start_i,
  input  logic  armed_i,
  input  mode_t mode_i,
  input  logic  bcd_i,
  input  cnt_t  init_i,
  input  logic  rise_i,
  input  logic  gate_i,
  input  logic  tick_i,
  output cnt_t  cnt_o,
  output logic  out_o,
  output logic  restart_o,
  output logic  term_o
);
  cnt_t cnt_q;
  logic out_q;
  logic done_q;
  logic run;
  logic two;
  cnt_t cnt_dec;

  assign two       = (mode_i == 3'd3);
  assign cnt_dec   = f_dec(cnt_q, bcd_i, two);
  assign restart_o = start_i || (armed_i && rise_i && f_retrig(mode_i));
  assign run       = armed_i && tick_i && (f_level_gated(mode_i) ? gate_i : 1'b1);
  assign term_o    = run && (cnt_q == (two ? cnt_t'(2) : cnt_t'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      out_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (restart_o) begin
      cnt_q  <= two ? f_even_up(init_i, bcd_i) : init_i;
      out_q  <= (mode_i == 3'd1) || (mode_i == 3'd3);
      done_q <= 1'b0;
    end else if (armed_i) begin
      if (f_pulse_mode(mode_i)) out_q <= 1'b0;
      if (run) begin
        case (mode_i)
          3'd0: begin
            cnt_q <= cnt_dec;
            if (term_o) out_q <= 1'b1;
          end
          3'd1: begin
            cnt_q <= cnt_dec;
            if (term_o) out_q <= 1'b0;
          end
          3'd2: begin
            if (term_o) begin
              cnt_q <= init_i;
              out_q <= 1'b1;
            end else begin
              cnt_q <= cnt_dec;
            end
          end
          3'd3: begin
            if (!term_o) begin
              cnt_q <= cnt_dec;
            end else if (out_q && init_i == cnt_t'(1)) begin
              cnt_q <= f_even_up(init_i, bcd_i);
            end else if (out_q) begin
              out_q <= 1'b0;
              cnt_q <= f_even_down(init_i);
            end else begin
              out_q <= 1'b1;
              cnt_q <= f_even_up(init_i, bcd_i);
            end
          end
          default: begin
            cnt_q <= cnt_dec;
            if (term_o && !done_q) begin
              out_q  <= 1'b1;
              done_q <= 1'b1;
            end
          end
        endcase
      end
    end
  end

  assign cnt_o = cnt_q;
  assign out_o = out_q;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  mode_i,
  input  logic        bcd_i,
  input  logic        load_i,
  input  logic [15:0] load_val_i,
  input  logic        gate_i,
  input  logic        tick_i,
  output logic [15:0] count_o,
  output logic        out_o
);
  logic  armed_w;
  logic  start_w;
  mode_t mode_w;
  logic  bcd_w;
  cnt_t  init_w;
  logic  rise_w;
  logic  restart_w;
  logic  term_w;

  tmr_edge i_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_i    (gate_i),
    .rise_o (rise_w)
  );

  tmr_cfg i_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_i),
    .mode_i  (mode_i),
    .bcd_i   (bcd_i),
    .val_i   (load_val_i),
    .armed_o (armed_w),
    .start_o (start_w),
    .mode_o  (mode_w),
    .bcd_o   (bcd_w),
    .init_o  (init_w)
  );

  tmr_core i_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_w),
    .armed_i   (armed_w),
    .mode_i    (mode_w),
    .bcd_i     (bcd_w),
    .init_i    (init_w),
    .rise_i    (rise_w),
    .gate_i    (gate_i),
    .tick_i    (tick_i),
    .cnt_o     (count_o),
    .out_o     (out_o),
    .restart_o (restart_w),
    .term_o    (term_w)
  );
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk
  import tmr_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        load_i,
  input logic [2:0]  mode_i,
  input logic [15:0] load_val_i,
  input logic        gate_i,
  input logic        tick_i,
  input logic [15:0] count_o,
  input logic        out_o,
  input logic        armed,
  input logic [2:0]  mode,
  input logic        bcd,
  input logic        rise,
  input logic        restart
);
  function automatic logic f_digits_ok(logic [15:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < DIG_N; i++) if (v[i*4 +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (!out_o && count_o == 16'd0));

  p_load_takes_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !f_periodic(f_norm_mode(mode_i))) |=> (count_o == $past(load_val_i)));

  p_flag_sticks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && mode == 3'd0 && out_o && !load_i) |=> out_o);

  p_strobe_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && (mode == 3'd4 || mode == 3'd5) && out_o) |=> !out_o);

  p_gate_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && (mode == 3'd0 || mode == 3'd4) && !gate_i && !load_i) |=> $stable(count_o));

  p_count_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_i && !rise) |=> $stable(count_o));

  p_restart_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && mode == 3'd1) |=> out_o);

  p_bcd_digits_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && bcd && !load_i) |-> f_digits_ok(count_o));
endmodule

bind tmr_channel tmr_channel_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .load_i     (load_i),
  .mode_i     (mode_i),
  .load_val_i (load_val_i),
  .gate_i     (gate_i),
  .tick_i     (tick_i),
  .count_o    (count_o),
  .out_o      (out_o),
  .armed      (armed_w),
  .mode       (mode_w),
  .bcd        (bcd_w),
  .rise       (rise_w),
  .restart    (restart_w)
);

// File: tb/test_tmr_channel.sv
module test_tmr_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode_i = '0;
  logic        bcd_i = 1'b0;
  logic        load_i = 1'b0;
  logic [15:0] load_val_i = '0;
  logic        gate_i = 1'b0;
  logic        tick_i = 1'b0;
  logic [15:0] count_o;
  logic        out_o;

  int    n_vec = 0;
  int    n_bad = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  tmr_channel i_tmr_channel (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .bcd_i(bcd_i), .load_i(load_i),
    .load_val_i(load_val_i), .gate_i(gate_i), .tick_i(tick_i),
    .count_o(count_o), .out_o(out_o)
  );

  // Behavioural reference: count kept as a plain integer value
  int m_armed, m_mode, m_bcd, m_init, m_cnt, m_out, m_done, m_gprev;

  function automatic int modulus(int b);
    return b ? 10000 : 65536;
  endfunction
  function automatic int from_code(logic [15:0] v, int b);
    if (!b) return int'(v);
    return v[15:12]*1000 + v[11:8]*100 + v[7:4]*10 + v[3:0];
  endfunction
  function automatic logic [15:0] to_code(int v, int b);
    logic [15:0] r;
    if (!b) return v[15:0];
    r[15:12] = 4'((v / 1000) % 10);
    r[11:8]  = 4'((v / 100) % 10);
    r[7:4]   = 4'((v / 10) % 10);
    r[3:0]   = 4'(v % 10);
    return r;
  endfunction

  task automatic m_restart();
    int md;
    md = modulus(m_bcd);
    m_cnt  = (m_mode == 3 && (m_init % 2) == 1) ? (m_init + 1) % md : m_init;
    m_out  = (m_mode == 1 || m_mode == 3) ? 1 : 0;
    m_done = 0;
  endtask

  task automatic m_run();
    int md, stp, hit;
    md = modulus(m_bcd);
    if (m_mode == 2 || m_mode == 4 || m_mode == 5) m_out = 0;
    if (!tick_i) return;
    if ((m_mode == 0 || m_mode == 4) && !gate_i) return;
    stp = (m_mode == 3) ? 2 : 1;
    hit = (m_cnt == stp);
    if (m_mode == 2 && hit) begin
      m_cnt = m_init; m_out = 1;
    end else if (m_mode == 3 && hit) begin
      if (m_out == 1 && m_init == 1) m_cnt = 2;
      else if (m_out == 1) begin m_out = 0; m_cnt = m_init - (m_init % 2); end
      else begin m_out = 1; m_cnt = (m_init + (m_init % 2)) % md; end
    end else begin
      m_cnt = (m_cnt - stp + md) % md;
      if (hit && m_mode == 0) m_out = 1;
      if (hit && m_mode == 1) m_out = 0;
      if (hit && (m_mode == 4 || m_mode == 5) && !m_done) begin m_out = 1; m_done = 1; end
    end
  endtask

  always @(posedge clk) begin
    int nm, rise, defer;
    if (!rst_n) begin
      m_armed = 0; m_mode = 0; m_bcd = 0; m_init = 0;
      m_cnt = 0; m_out = 0; m_done = 0; m_gprev = 0;
    end else begin
      rise = (gate_i && !m_gprev) ? 1 : 0;
      m_gprev = gate_i;
      defer = 0;
      if (load_i) begin
        nm = (mode_i > 5) ? int'(mode_i) - 4 : int'(mode_i);
        defer = (m_armed && nm == m_mode && (nm == 2 || nm == 3) && int'(bcd_i) == m_bcd) ? 1 : 0;
        m_mode = nm; m_bcd = bcd_i; m_init = from_code(load_val_i, bcd_i); m_armed = 1;
      end
      if (load_i && !defer) m_restart();
      else if (m_armed && rise && m_mode inside {1, 2, 3, 5}) m_restart();
      else if (m_armed) m_run();
    end
  end

  always @(negedge clk) begin
    logic [15:0] ec;
    if (rst_n) begin
      ec = m_armed ? to_code(m_cnt, m_bcd) : 16'd0;
      n_vec++;
      if (count_o !== ec || out_o !== m_out[0]) begin
        n_bad++;
        $display("FAIL %s: count=%h out=%b expected count=%h out=%0d", cur_req, count_o, out_o, ec, m_out);
      end
    end
  end

  task automatic cyc(input logic ld, input logic [2:0] md, input logic bc,
                     input logic [15:0] v, input logic g, input logic tk);
    load_i = ld; mode_i = md; bcd_i = bc; load_val_i = v; gate_i = g; tick_i = tk;
    @(negedge clk);
  endtask

  task automatic ticks(input int n, input logic g, input int gap);
    for (int i = 0; i < n; i++) begin
      cyc(1'b0, mode_i, bcd_i, load_val_i, g, 1'b1);
      for (int j = 0; j < gap; j++) cyc(1'b0, mode_i, bcd_i, load_val_i, g, 1'b0);
    end
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle before first load
    check("R1", {15'd0, out_o}, 16'd0);
    check("R1", count_o, 16'd0);
    cur_req = "R1";
    ticks(4, 1'b1, 0);
    cyc(0, 0, 0, 0, 1'b0, 1'b1);
    cyc(0, 0, 0, 0, 1'b1, 1'b1);
    check("R1", count_o, 16'd0);

    // R4 / R10: terminal flag, gate suspends
    cur_req = "R4";
    cyc(1, 3'd0, 0, 16'd5, 1'b1, 1'b0);
    ticks(3, 1'b1, 0);
    cur_req = "R10";
    ticks(3, 1'b0, 0);
    cyc(0, 3'd0, 0, 16'd5, 1'b1, 1'b0);
    cur_req = "R4";
    ticks(4, 1'b1, 1);
    check("R4", {15'd0, out_o}, 16'd1);
    // R11: immediate reload in mode 0
    cur_req = "R11";
    cyc(1, 3'd0, 0, 16'd9, 1'b1, 1'b0);
    ticks(3, 1'b1, 0);
    cyc(1, 3'd0, 0, 16'd4, 1'b1, 1'b1);
    check("R11", count_o, 16'd4);
    ticks(5, 1'b1, 0);

    // R5: one-shot, gate edge restarts
    cur_req = "R5";
    cyc(1, 3'd1, 0, 16'd4, 1'b0, 1'b0);
    ticks(2, 1'b0, 0);
    cur_req = "R10";
    cyc(0, 3'd1, 0, 16'd4, 1'b1, 1'b1);
    cur_req = "R5";
    ticks(6, 1'b1, 0);
    check("R5", {15'd0, out_o}, 16'd0);
    ticks(2, 1'b0, 0);

    // R6: rate pulses, deferred reload
    cur_req = "R6";
    cyc(1, 3'd2, 0, 16'd3, 1'b1, 1'b0);
    ticks(7, 1'b1, 1);
    cur_req = "R11";
    cyc(1, 3'd2, 0, 16'd5, 1'b1, 1'b1);
    ticks(12, 1'b1, 0);
    cur_req = "R6";
    cyc(1, 3'd2, 0, 16'd1, 1'b0, 1'b0);
    ticks(4, 1'b0, 0);

    // R7 / R2: square wave, alias code 7
    cur_req = "R7";
    cyc(1, 3'd3, 0, 16'd6, 1'b0, 1'b0);
    ticks(14, 1'b0, 0);
    cur_req = "R2";
    cyc(1, 3'd7, 0, 16'd5, 1'b0, 1'b0);
    ticks(12, 1'b0, 1);
    cur_req = "R7";
    cyc(1, 3'd3, 0, 16'd1, 1'b0, 1'b0);
    ticks(5, 1'b0, 0);
    check("R7", {15'd0, out_o}, 16'd1);
    cur_req = "R10";
    cyc(1, 3'd6, 0, 16'd4, 1'b0, 1'b0);
    ticks(3, 1'b0, 0);
    cyc(0, 3'd6, 0, 16'd4, 1'b1, 1'b1);
    ticks(5, 1'b1, 0);

    // R8: software strobe, gated
    cur_req = "R8";
    cyc(1, 3'd4, 0, 16'd3, 1'b1, 1'b0);
    ticks(1, 1'b1, 0);
    ticks(2, 1'b0, 0);
    cyc(0, 3'd4, 0, 16'd3, 1'b1, 1'b0);
    ticks(5, 1'b1, 0);

    // R9: gate-started strobe, level ignored
    cur_req = "R9";
    cyc(1, 3'd5, 0, 16'd3, 1'b0, 1'b0);
    ticks(4, 1'b0, 0);
    cyc(0, 3'd5, 0, 16'd3, 1'b1, 1'b0);
    ticks(4, 1'b1, 0);

    // R12: simultaneous events
    cur_req = "R12";
    cyc(1, 3'd5, 0, 16'd2, 1'b0, 1'b0);
    cyc(0, 3'd5, 0, 16'd2, 1'b0, 1'b1);
    cyc(0, 3'd5, 0, 16'd2, 1'b1, 1'b1);
    check("R12", count_o, 16'd2);
    cyc(1, 3'd2, 0, 16'd7, 1'b0, 1'b1);
    cyc(1, 3'd1, 0, 16'd3, 1'b1, 1'b1);
    check("R12", count_o, 16'd3);
    ticks(3, 1'b1, 0);
    cyc(0, 3'd1, 0, 16'd3, 1'b1, 1'b0);
    check("R12", count_o, count_o);

    // R13 / R3: BCD counting and wrap to 9999
    cur_req = "R13";
    cyc(1, 3'd0, 1, 16'h0003, 1'b1, 1'b0);
    ticks(3, 1'b1, 0);
    cur_req = "R3";
    ticks(1, 1'b1, 0);
    check("R3", count_o, 16'h9999);
    cur_req = "R13";
    cyc(1, 3'd2, 1, 16'h0012, 1'b0, 1'b0);
    ticks(26, 1'b0, 0);
    cyc(1, 3'd3, 1, 16'h0011, 1'b0, 1'b0);
    ticks(24, 1'b0, 0);

    // R3 binary wrap
    cur_req = "R3";
    cyc(1, 3'd1, 0, 16'd2, 1'b0, 1'b0);
    ticks(3, 1'b0, 0);
    check("R3", count_o, 16'hFFFF);

    // R2: zero means maximum
    cur_req = "R2";
    cyc(1, 3'd0, 0, 16'd0, 1'b1, 1'b0);
    ticks(1, 1'b1, 0);
    check("R2", count_o, 16'hFFFF);
    ticks(65534, 1'b1, 0);
    check("R2", {15'd0, out_o}, 16'd0);
    ticks(1, 1'b1, 0);
    check("R2", {15'd0, out_o}, 16'd1);
    check("R2", count_o, 16'd0);
    cyc(1, 3'd4, 1, 16'h0000, 1'b1, 1'b0);
    ticks(1, 1'b1, 0);
    check("R2", count_o, 16'h9999);
    ticks(9999, 1'b1, 0);
    check("R2", {15'd0, out_o}, 16'd1);
    ticks(3, 1'b1, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule